// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits at the decode stage of an in-order-issue pipeline whose results may complete out of order. It has four execution paths: a single-cycle integer path for ALU operations, loads, stores and branches, a pipelined FP adder, a pipelined multiplier, and a divider that is not pipelined. Each cycle it looks at the decoded instruction: its class, up to two source registers, a destination register and a flag that picks the integer or FP register file. It raises a stall when issuing now would cause a write-port collision, read a value that is not ready yet, or let an older write land after a younger one.

While the stall is high, the decode stage and everything behind it hold their contents. Instructions already issued keep moving. When the instruction issues, the block enters its destination into a timing wheel. Each slot of the wheel stands for one future cycle. The wheel shifts one slot per clock. The slot that reaches position zero drives the write-back outputs, so the bench can see each write in the cycle it happens. Only stage occupancy and timing are modelled, not data.

Top module: `fp_iss_interlock`

## Requirements
- R1: After a synchronous active-high reset, no write-back is signalled, `div_busy` is low, and an idle decode stage (`id_valid` low) does not stall.
- R2: Class codes on `id_cls` are: 0 integer ALU, 1 load, 2 store, 3 branch, 4 FP add, 5 multiply, 6 divide. An instruction of a writing class issued in cycle c shows `wb_valid`, with its `wb_dst` and `wb_fp`, in the cycle given by its class: c+2 for ALU and load, c+ADD_DEPTH+1 for add, c+MUL_DEPTH+1 for multiply, c+DIV_CYCLES+1 for divide.
- R3: No two write-backs ever fall in the same cycle. An instruction whose write-back cycle is already taken stalls until its cycle is free.
- R4: A divide issued in cycle c holds `div_busy` high and stalls any further divide until cycle c+DIV_CYCLES.
- R5: A consumer whose source register, in the same file, is the destination of an in-flight producer stalls until the result is ready. For add, multiply, divide and ALU producers, ready means the unit's execute depth in cycles after the producer issued (ALU depth 1). For a load producer it is 2 cycles after issue.
- R6: An instruction that writes a register stalls while an earlier instruction targeting the same register in the same file is still in an execute stage, that is, two or more cycles before its write-back.
- R7: Register comparisons are made only within one file. An integer register and an FP register with the same number never cause a hazard.
- R8: Stores and branches produce no write-back, reserve no write-port cycle and never take part in the destination hazard check.
- R9: While the decode stage stalls, instructions already issued still write back in their scheduled cycles.
- R10: `id_stall` is high only when `id_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_cls | input | 3 | Instruction class code |
| id_fp | input | 1 | Operands and destination are in the FP register file |
| id_src1_en | input | 1 | First source register is used |
| id_src1 | input | 5 | First source register number |
| id_src2_en | input | 1 | Second source register is used |
| id_src2 | input | 5 | Second source register number |
| id_dst | input | 5 | Destination register number |
| id_stall | output | 1 | Hold the decode stage this cycle |
| div_busy | output | 1 | Divider occupied by an earlier divide |
| wb_valid | output | 1 | A register write-back happens this cycle |
| wb_fp | output | 1 | Write-back targets the FP file |
| wb_dst | output | 5 | Write-back destination register |

## Verification
The bench builds the block with its default depths: a 4-stage adder, a 7-stage multiplier and a 24-cycle divider, which makes the timing wheel 26 slots long. These values keep the divide-after-divide and divide-then-add cases short enough to run, and they still put the longest reservation at the far end of the wheel. They also let short runs of ALU operations land exactly on a multiply's or an add's write-back slot, so a single-cycle port collision can be forced.

// File: rtl/fp_iss_pkg.sv
package fp_iss_pkg;

    localparam int REG_W = 5;

    typedef enum logic [2:0] {
        CLS_INT    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_FADD   = 3'd4,
        CLS_FMUL   = 3'd5,
        CLS_FDIV   = 3'd6
    } op_cls_e;

    // One pending write-back: which file, whether a load made it, target register
    typedef struct packed {
        logic             vld;
        logic             fp;
        logic             ld;
        logic [REG_W-1:0] dst;
    } wb_ent_t;

    function automatic logic cls_writes(op_cls_e c);
        return !(c == CLS_STORE || c == CLS_BRANCH);
    endfunction

    // Cycles from issue to the write-back cycle
    function automatic int unsigned wb_offset(op_cls_e c, int unsigned add_d,
                                              int unsigned mul_d, int unsigned div_c);
        case (c)
            CLS_FADD: return add_d + 1;
            CLS_FMUL: return mul_d + 1;
            CLS_FDIV: return div_c + 1;
            default:  return 2;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fp_iss_wheel.sv
module fp_iss_wheel
    import fp_iss_pkg::*;
#(
    parameter int NSLOT = 26,
    parameter int OFF_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins,
    input  logic [OFF_W-1:0] ins_off,
    input  wb_ent_t          ins_ent,
    output wb_ent_t          slot [NSLOT]
);

    wb_ent_t nxt [NSLOT];

    // Slot k holds the write k cycles away; an insert at offset o lands in o-1
    always_comb begin
        for (int k = 0; k < NSLOT; k++) begin
            if (k < NSLOT - 1) nxt[k] = slot[k+1];
            else               nxt[k] = '0;
            if (ins && ins_off == OFF_W'(k + 1)) nxt[k] = ins_ent;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NSLOT; k++) begin
            if (rst) slot[k] <= '0;
            else     slot[k] <= nxt[k];
        end
    end

endmodule

// File: rtl/fp_iss_divtrk.sv
module fp_iss_divtrk #(
    parameter int DIV_CYCLES = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(DIV_CYCLES + 1);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)          left <= '0;
        else if (start)   left <= CNT_W'(DIV_CYCLES - 1);
        else if (busy)    left <= left - 1'b1;
    end

    assign busy = (left != '0);

endmodule

// File: rtl/fp_iss_hazard.sv
module fp_iss_hazard
    import fp_iss_pkg::*;
#(
    parameter int NSLOT = 26,
    parameter int OFF_W = 5
) (
    input  wb_ent_t          slot [NSLOT],
    input  logic             valid,
    input  logic             writes,
    input  logic             is_div,
    input  logic             div_busy,
    input  logic [OFF_W-1:0] off,
    input  logic             fp,
    input  logic             s1_en,
    input  logic [REG_W-1:0] s1,
    input  logic             s2_en,
    input  logic [REG_W-1:0] s2,
    input  logic [REG_W-1:0] dst,
    output logic             stall
);

    logic port_hit, raw_hit, waw_hit;

    always_comb begin
        port_hit = 1'b0;
        raw_hit  = 1'b0;
        waw_hit  = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            logic same_file, src_match, not_ready;
            same_file = slot[k].vld && (slot[k].fp == fp);
            src_match = (s1_en && slot[k].dst == s1) || (s2_en && slot[k].dst == s2);
            not_ready = (k >= 2) || (k == 1 && slot[k].ld);
            if (same_file && src_match && not_ready) raw_hit = 1'b1;
            if (writes && same_file && slot[k].dst == dst && k >= 2) waw_hit = 1'b1;
            if (writes && slot[k].vld && off == OFF_W'(k)) port_hit = 1'b1;
        end
    end

    assign stall = valid && (port_hit || raw_hit || waw_hit || (is_div && div_busy));

endmodule

// File: rtl/fp_iss_interlock.sv
module fp_iss_interlock
    import fp_iss_pkg::*;
#(
    parameter int ADD_DEPTH  = 4,
    parameter int MUL_DEPTH  = 7,
    parameter int DIV_CYCLES = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [2:0]       id_cls,
    input  logic             id_fp,
    input  logic             id_src1_en,
    input  logic [REG_W-1:0] id_src1,
    input  logic             id_src2_en,
    input  logic [REG_W-1:0] id_src2,
    input  logic [REG_W-1:0] id_dst,
    output logic             id_stall,
    output logic             div_busy,
    output logic             wb_valid,
    output logic             wb_fp,
    output logic [REG_W-1:0] wb_dst
);

    localparam int MAX_OFF = int'(max3(ADD_DEPTH, MUL_DEPTH, DIV_CYCLES)) + 1;
    localparam int NSLOT   = MAX_OFF + 1;
    localparam int OFF_W   = $clog2(NSLOT);

    op_cls_e          cls;
    logic             writes, is_div, issue;
    logic [OFF_W-1:0] off;
    wb_ent_t          new_ent;
    wb_ent_t          slot [NSLOT];

    assign cls     = op_cls_e'(id_cls);
    assign writes  = id_valid && cls_writes(cls);
    assign is_div  = (cls == CLS_FDIV);
    assign off     = OFF_W'(wb_offset(cls, ADD_DEPTH, MUL_DEPTH, DIV_CYCLES));
    assign issue   = id_valid && !id_stall;
    assign new_ent = '{vld: 1'b1, fp: id_fp, ld: (cls == CLS_LOAD), dst: id_dst};

    fp_iss_wheel #(.NSLOT(NSLOT), .OFF_W(OFF_W)) wheel_i (
        .clk     (clk),
        .rst     (rst),
        .ins     (issue && writes),
        .ins_off (off),
        .ins_ent (new_ent),
        .slot    (slot)
    );

    fp_iss_divtrk #(.DIV_CYCLES(DIV_CYCLES)) divtrk_i (
        .clk   (clk),
        .rst   (rst),
        .start (issue && is_div),
        .busy  (div_busy)
    );

    fp_iss_hazard #(.NSLOT(NSLOT), .OFF_W(OFF_W)) hazard_i (
        .slot     (slot),
        .valid    (id_valid),
        .writes   (writes),
        .is_div   (is_div),
        .div_busy (div_busy),
        .off      (off),
        .fp       (id_fp),
        .s1_en    (id_src1_en),
        .s1       (id_src1),
        .s2_en    (id_src2_en),
        .s2       (id_src2),
        .dst      (id_dst),
        .stall    (id_stall)
    );

    assign wb_valid = slot[0].vld;
    assign wb_fp    = slot[0].fp;
    assign wb_dst   = slot[0].dst;

endmodule

// File: rtl/fp_iss_chk.sv
module fp_iss_chk (
    input logic       clk,
    input logic       rst,
    input logic       id_valid,
    input logic [2:0] id_cls,
    input logic       id_fp,
    input logic [4:0] id_dst,
    input logic       id_stall,
    input logic       div_busy,
    input logic       wb_valid,
    input logic       wb_fp,
    input logic [4:0] wb_dst
);

    // R10
    a_r10_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
        id_stall |-> id_valid);

    // R4
    a_r4_div_blocks_div: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_cls == 3'd6 && div_busy) |-> id_stall);

    a_r4_busy_after_div: assert property (@(posedge clk) disable iff (rst)
        (id_valid && !id_stall && id_cls == 3'd6) |=> div_busy);

    // R2: ALU op writes back two cycles after issue
    a_r2_alu_wb_time: assert property (@(posedge clk) disable iff (rst)
        (id_valid && !id_stall && id_cls == 3'd0) |-> ##2
        (wb_valid && wb_dst == $past(id_dst, 2) && wb_fp == $past(id_fp, 2)));

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!wb_valid && !div_busy));

endmodule

bind fp_iss_interlock fp_iss_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .id_valid (id_valid),
    .id_cls   (id_cls),
    .id_fp    (id_fp),
    .id_dst   (id_dst),
    .id_stall (id_stall),
    .div_busy (div_busy),
    .wb_valid (wb_valid),
    .wb_fp    (wb_fp),
    .wb_dst   (wb_dst)
);

// File: tb/fp_iss_interlock_tb_top.sv
module fp_iss_interlock_tb_top;

    localparam int ADD_D = 4;
    localparam int MUL_D = 7;
    localparam int DIV_C = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [2:0] id_cls = 3'd0;
    logic       id_fp = 1'b0;
    logic       id_src1_en = 1'b0;
    logic [4:0] id_src1 = '0;
    logic       id_src2_en = 1'b0;
    logic [4:0] id_src2 = '0;
    logic [4:0] id_dst = '0;
    logic       id_stall, div_busy, wb_valid, wb_fp;
    logic [4:0] wb_dst;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int stall_seen = 0;
    int stall_want = 0;

    typedef struct {
        int         when;
        logic       fp;
        logic [4:0] dst;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    fp_iss_interlock #(.ADD_DEPTH(ADD_D), .MUL_DEPTH(MUL_D), .DIV_CYCLES(DIV_C)) dut_i (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_cls(id_cls), .id_fp(id_fp),
        .id_src1_en(id_src1_en), .id_src1(id_src1), .id_src2_en(id_src2_en),
        .id_src2(id_src2), .id_dst(id_dst), .id_stall(id_stall), .div_busy(div_busy),
        .wb_valid(wb_valid), .wb_fp(wb_fp), .wb_dst(wb_dst)
    );

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int off_of(input logic [2:0] c);
        case (c)
            3'd4: return ADD_D + 1;
            3'd5: return MUL_D + 1;
            3'd6: return DIV_C + 1;
            default: return 2;
        endcase
    endfunction

    // Driver: present one instruction, hold it while stalled, schedule its write-back
    task automatic op(input string tag, input logic [2:0] c, input logic fp,
                      input logic s1e, input logic [4:0] s1,
                      input logic s2e, input logic [4:0] s2,
                      input logic [4:0] d, input int exp_ns);
        int ns;
        @(negedge clk);
        id_valid = 1'b1; id_cls = c; id_fp = fp;
        id_src1_en = s1e; id_src1 = s1; id_src2_en = s2e; id_src2 = s2; id_dst = d;
        ns = 0;
        #1;
        while (id_stall) begin
            ns++;
            @(negedge clk);
            #1;
        end
        if (c != 3'd2 && c != 3'd3)
            q.push_back('{when: cyc + off_of(c), fp: fp, dst: d});
        stall_seen += ns;
        stall_want += exp_ns;
        chk(tag, ns == exp_ns, ns, exp_ns);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        id_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every write-back must match a scheduled item for this exact cycle
    always @(negedge clk) begin
        if (!rst) begin
            int idx;
            idx = -1;
            foreach (q[i]) if (q[i].when == cyc) idx = i;
            if (wb_valid) begin
                if (idx < 0) chk("R3/R8 unexpected write-back", 1'b0, int'(wb_dst), -1);
                else begin
                    chk("R2/R9 write-back register", wb_dst == q[idx].dst && wb_fp == q[idx].fp,
                        int'({wb_fp, wb_dst}), int'({q[idx].fp, q[idx].dst}));
                    q.delete(idx);
                end
            end else if (idx >= 0) begin
                chk("R2/R3 missing write-back", 1'b0, 0, int'(q[idx].dst));
                q.delete(idx);
            end
        end
    end

    initial begin
        #(20 * 150000);
        chk("watchdog expired", 1'b0, 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall after reset", id_stall == 1'b0, id_stall, 0);
        chk("R1 wb after reset", wb_valid == 1'b0, wb_valid, 0);
        chk("R1 div_busy after reset", div_busy == 1'b0, div_busy, 0);

        // R2: independent ALU ops, no stalls
        op("R2 alu 1", 3'd0, 0, 0, 0, 0, 0, 5'd1, 0);
        op("R2 alu 2", 3'd0, 0, 0, 0, 0, 0, 5'd2, 0);
        op("R2 alu 3", 3'd0, 0, 0, 0, 0, 0, 5'd3, 0);
        op("R2 load", 3'd1, 0, 0, 0, 0, 0, 5'd4, 0);
        idle(30);

        // R5: load-use, ALU-use
        op("R5 load", 3'd1, 0, 0, 0, 0, 0, 5'd3, 0);
        op("R5 load use", 3'd0, 0, 1, 5'd3, 0, 0, 5'd5, 1);
        op("R5 alu", 3'd0, 0, 0, 0, 0, 0, 5'd4, 0);
        op("R5 alu use", 3'd0, 0, 0, 0, 1, 5'd4, 5'd6, 0);
        idle(30);

        // R5: add-use and multiply-use
        op("R5 fadd", 3'd4, 1, 0, 0, 0, 0, 5'd3, 0);
        op("R5 fadd use", 3'd4, 1, 1, 5'd3, 0, 0, 5'd8, 3);
        idle(30);
        op("R5 fmul", 3'd5, 1, 0, 0, 0, 0, 5'd9, 0);
        op("R5 fmul use", 3'd4, 1, 0, 0, 1, 5'd9, 5'd10, 6);
        idle(30);

        // R3/R9: write-port collision with a multiply, earlier ops keep writing back
        op("R3 fmul", 3'd5, 1, 0, 0, 0, 0, 5'd11, 0);
        for (int i = 0; i < 5; i++)
            op("R3 alu fill", 3'd0, 0, 0, 0, 0, 0, 5'(10 + i), 0);
        op("R3 R9 alu collides", 3'd0, 0, 0, 0, 0, 0, 5'd15, 1);
        idle(30);
        op("R3 fadd", 3'd4, 1, 0, 0, 0, 0, 5'd12, 0);
        op("R3 alu a", 3'd0, 0, 0, 0, 0, 0, 5'd16, 0);
        op("R3 alu b", 3'd0, 0, 0, 0, 0, 0, 5'd17, 0);
        op("R3 alu collides with add", 3'd0, 0, 0, 0, 0, 0, 5'd18, 1);
        idle(30);

        // R6/R7: same destination
        op("R6 fmul", 3'd5, 1, 0, 0, 0, 0, 5'd13, 0);
        op("R6 fadd same dst", 3'd4, 1, 0, 0, 0, 0, 5'd13, 6);
        idle(30);
        op("R7 fmul fp dst", 3'd5, 1, 0, 0, 0, 0, 5'd14, 0);
        op("R7 alu int same number", 3'd0, 0, 1, 5'd14, 0, 0, 5'd14, 0);
        idle(30);

        // R4/R10: divider occupancy
        op("R4 div 1", 3'd6, 1, 0, 0, 0, 0, 5'd20, 0);
        @(negedge clk);
        id_valid = 1'b0; id_cls = 3'd6;
        #1;
        chk("R4 div_busy after divide", div_busy == 1'b1, div_busy, 1);
        chk("R10 no stall when idle", id_stall == 1'b0, id_stall, 0);
        op("R4 div 2", 3'd6, 1, 0, 0, 0, 0, 5'd21, 22);
        idle(60);
        op("R6 div", 3'd6, 1, 0, 0, 0, 0, 5'd22, 0);
        op("R6 fadd after div same dst", 3'd4, 1, 0, 0, 0, 0, 5'd22, 23);
        idle(40);

        // R8: store and branch skip reservation and destination check
        op("R8 fmul", 3'd5, 1, 0, 0, 0, 0, 5'd23, 0);
        op("R8 store same dst field", 3'd2, 1, 0, 0, 0, 0, 5'd23, 0);
        for (int i = 0; i < 4; i++)
            op("R8 alu fill", 3'd0, 0, 0, 0, 0, 0, 5'(24 + i), 0);
        op("R8 branch on wb slot", 3'd3, 0, 0, 0, 0, 0, 5'd28, 0);
        op("R8 alu after branch", 3'd0, 0, 0, 0, 0, 0, 5'd29, 0);
        idle(40);

        chk("R2 all write-backs seen", q.size() == 0, q.size(), 0);
        chk("R3 total stall cycles", stall_seen == stall_want, stall_seen, stall_want);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule